// File: doc/BRIEF.md
# Four-Character Buffered Serial Receiver

This block receives one asynchronous serial line and turns it into characters for a processor. The line is sampled on a 16x oversampling enable. A character starts with a low start bit, which is confirmed halfway through its cell. Then come five to eight data bits, an optional parity bit and a stop bit. Each character is stored in a small queue together with its own error flags, and the processor takes characters from the front of the queue with a pop strobe.

The queue is four characters deep. Three holding slots sit in front of a fourth slot. A finished character waits in that fourth slot when the holding slots are all taken. A character that finishes while all four are occupied is dropped, and a sticky overrun flag is raised.

A line held at space for a whole character is reported as a break. The break goes into the queue once, and single-cycle pulses mark its start and its end. This also works when the line drops in the middle of a character.

Top module: `uart_rx_quad`

## Requirements
- R1: The data length is `cfg_len`+5 bits (00 gives 5, 11 gives 8). The first data bit on the line lands in `rd_data[0]`, and unused upper bits of `rd_data` read zero.
- R2: `cfg_par` selects parity: 00 even (data plus parity bit has an even count of ones), 01 odd, 10 forced (the parity bit must equal `cfg_force`), 11 no parity bit. A mismatch sets `st_parity` for that character only.
- R3: The line idles high. A low level that is no longer low eight oversampling ticks later is discarded, and no character is stored.
- R4: A character whose stop bit is sampled low, and whose content is not all zero, is stored with `st_framing` set and its data intact.
- R5: A character with zero data, a zero parity bit when parity is used, and a low stop bit is a break. One 0x00 entry with `st_break` set is stored for the whole break, `brk_start` pulses once, and `brk_end` pulses once when the line returns high. A break that begins mid-character yields the interrupted character with a framing error, followed by the break entry.
- R6: `rd_ready` is high while at least one character is held. `rd_full` is high while four are held. After reset both are low, as are `st_overrun` and `rd_data`.
- R7: Characters are delivered in arrival order. Each `pop` while `rd_ready` is high advances to the next character. A `pop` while empty has no effect.
- R8: A character that completes while four are held is discarded, and the held characters stay unchanged. `st_overrun` then stays high until `err_clr` is pulsed.
- R9: A character completing in the same cycle as a `pop` is neither lost nor counted as an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit cell |
| rxd | input | 1 | Serial input, high is mark |
| cfg_len | input | 2 | Data length select, length = value+5 |
| cfg_par | input | 2 | Parity mode: even, odd, forced, none |
| cfg_force | input | 1 | Expected parity bit level in forced mode |
| pop | input | 1 | Remove the front character |
| err_clr | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Front character data |
| rd_ready | output | 1 | At least one character held |
| rd_full | output | 1 | Four characters held |
| st_parity | output | 1 | Front character parity error |
| st_framing | output | 1 | Front character framing error |
| st_break | output | 1 | Front character is a break |
| st_overrun | output | 1 | Sticky overrun flag |
| brk_start | output | 1 | Pulse when a break is recognised |
| brk_end | output | 1 | Pulse when the line returns high after a break |

## Verification
A character can be completed by the deframer in the very cycle in which the processor pops the queue. With three characters held, that collision decides whether the new one enters a holding slot directly or waits in the fourth slot. The bench fills three slots, then sweeps the pop across a window of thirty-two consecutive cycles around the stop-bit sample of a fourth character. Every offset must leave no overrun and must return the remaining characters in order, followed by an empty queue.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        PAR_EVEN  = 2'b00,
        PAR_ODD   = 2'b01,
        PAR_FORCE = 2'b10,
        PAR_NONE  = 2'b11
    } par_mode_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BRK
    } rx_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_char_t;

    // parity bit the line must carry for a given data word
    function automatic logic want_parity(input logic [7:0] d, input par_mode_t m,
                                         input logic f);
        logic r;
        unique case (m)
            PAR_EVEN:  r = ^d;
            PAR_ODD:   r = ~(^d);
            PAR_FORCE: r = f;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

    // index of the last data bit for a length select (5..8 bits)
    function automatic logic [2:0] last_bit(input logic [1:0] sel);
        return 3'd4 + {1'b0, sel};
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_deframe.sv
module uart_rx_deframe
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rx,
    input  logic [1:0] len_sel,
    input  par_mode_t pmode,
    input  logic      pforce,
    output logic      chr_vld,
    output rx_char_t  chr,
    output logic      brk_on,
    output logic      brk_off
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_t      state;
    logic [CW-1:0]  cnt;
    logic [2:0]     bidx;
    logic [7:0]     shreg;
    logic           pbit;
    logic           zero_body;

    assign zero_body = (shreg == 8'h00) && ((pmode == PAR_NONE) || !pbit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            cnt     <= '0;
            bidx    <= '0;
            shreg   <= '0;
            pbit    <= 1'b0;
            chr_vld <= 1'b0;
            chr     <= '0;
            brk_on  <= 1'b0;
            brk_off <= 1'b0;
        end else begin
            chr_vld <= 1'b0;
            brk_on  <= 1'b0;
            brk_off <= 1'b0;
            if (tick) begin
                unique case (state)
                    S_IDLE: begin
                        if (!rx) begin
                            state <= S_START;
                            cnt   <= '0;
                        end
                    end
                    S_START: begin
                        if (cnt == MID) begin
                            cnt   <= '0;
                            bidx  <= '0;
                            shreg <= '0;
                            pbit  <= 1'b0;
                            state <= rx ? S_IDLE : S_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (cnt == LAST) begin
                            cnt         <= '0;
                            shreg[bidx] <= rx;
                            if (bidx == last_bit(len_sel))
                                state <= (pmode == PAR_NONE) ? S_STOP : S_PAR;
                            else
                                bidx <= bidx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_PAR: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            pbit  <= rx;
                            state <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (cnt == LAST) begin
                            cnt      <= '0;
                            chr_vld  <= 1'b1;
                            chr.data <= shreg;
                            if (!rx && zero_body) begin
                                chr.perr <= 1'b0;
                                chr.ferr <= 1'b0;
                                chr.brk  <= 1'b1;
                                brk_on   <= 1'b1;
                                state    <= S_BRK;
                            end else begin
                                chr.perr <= (pmode != PAR_NONE) &&
                                            (pbit != want_parity(shreg, pmode, pforce));
                                chr.ferr <= !rx;
                                chr.brk  <= 1'b0;
                                state    <= S_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_BRK: begin
                        if (rx) begin
                            brk_off <= 1'b1;
                            state   <= S_IDLE;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  rx_char_t push_ent,
    input  logic     pop,
    input  logic     err_clr,
    output rx_char_t head,
    output logic     ready,
    output logic     full,
    output logic     overrun
);
    localparam int HOLD = DEPTH - 1;
    localparam int PW   = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam int CW   = $clog2(HOLD + 1);

    rx_char_t       mem [HOLD];
    logic [PW-1:0]  wptr, rptr;
    logic [CW-1:0]  count;
    rx_char_t       park, park_n, wr_ent;
    logic           park_vld, park_vld_n;
    logic           wr_en, pop_ok, space, ovr_set;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(HOLD - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop_ok = pop && (count != '0);
    assign space  = (count != CW'(HOLD)) || pop_ok;

    always_comb begin
        wr_en      = 1'b0;
        wr_ent     = push_ent;
        park_n     = park;
        park_vld_n = park_vld;
        ovr_set    = 1'b0;
        if (park_vld) begin
            if (space) begin
                wr_en      = 1'b1;
                wr_ent     = park;
                park_vld_n = push;
                park_n     = push_ent;
            end else if (push) begin
                ovr_set = 1'b1;
            end
        end else if (push) begin
            if (space) begin
                wr_en = 1'b1;
            end else begin
                park_vld_n = 1'b1;
                park_n     = push_ent;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            park     <= '0;
            park_vld <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (wr_en)  wptr <= nxt(wptr);
            if (pop_ok) rptr <= nxt(rptr);
            unique case ({wr_en, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
            park     <= park_n;
            park_vld <= park_vld_n;
            overrun  <= ovr_set | (overrun & ~err_clr);
        end
    end

    assign head  = mem[rptr];
    assign ready = (count != '0);
    assign full  = (count == CW'(HOLD)) && park_vld;
endmodule

// File: rtl/uart_rx_quad.sv
module uart_rx_quad
    import uart_rx_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int DEPTH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic       cfg_force,
    input  logic       pop,
    input  logic       err_clr,
    output logic [7:0] rd_data,
    output logic       rd_ready,
    output logic       rd_full,
    output logic       st_parity,
    output logic       st_framing,
    output logic       st_break,
    output logic       st_overrun,
    output logic       brk_start,
    output logic       brk_end
);
    logic      rx_s;
    logic      chr_vld;
    rx_char_t  chr, head;
    par_mode_t pmode;

    assign pmode = par_mode_t'(cfg_par);

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (rxd),
        .dout(rx_s)
    );

    uart_rx_deframe #(.OSR(OSR)) u_deframe (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick16),
        .rx     (rx_s),
        .len_sel(cfg_len),
        .pmode  (pmode),
        .pforce (cfg_force),
        .chr_vld(chr_vld),
        .chr    (chr),
        .brk_on (brk_start),
        .brk_off(brk_end)
    );

    uart_rx_buf #(.DEPTH(DEPTH)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .push    (chr_vld),
        .push_ent(chr),
        .pop     (pop),
        .err_clr (err_clr),
        .head    (head),
        .ready   (rd_ready),
        .full    (rd_full),
        .overrun (st_overrun)
    );

    assign rd_data    = rd_ready ? head.data : 8'h00;
    assign st_parity  = rd_ready & head.perr;
    assign st_framing = rd_ready & head.ferr;
    assign st_break   = rd_ready & head.brk;
endmodule

// File: rtl/uart_rx_quad_chk.sv
module uart_rx_quad_chk (
    input logic clk,
    input logic rst,
    input logic pop,
    input logic err_clr,
    input logic rd_ready,
    input logic rd_full,
    input logic st_overrun,
    input logic brk_start,
    input logic brk_end
);
    assert_full_implies_ready_R6: assert property (@(posedge clk) disable iff (rst)
        rd_full |-> rd_ready);

    assert_ready_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_ready && !pop) |=> rd_ready);

    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (st_overrun && !err_clr) |=> st_overrun);

    assert_overrun_needs_full_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(st_overrun) |-> $past(rd_full));

    assert_break_edges_apart_R5: assert property (@(posedge clk) disable iff (rst)
        !(brk_start && brk_end));

    assert_break_end_after_start_R5: assert property (@(posedge clk) disable iff (rst)
        brk_start |=> !brk_end);
endmodule

bind uart_rx_quad uart_rx_quad_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pop       (pop),
    .err_clr   (err_clr),
    .rd_ready  (rd_ready),
    .rd_full   (rd_full),
    .st_overrun(st_overrun),
    .brk_start (brk_start),
    .brk_end   (brk_end)
);

// File: tb/uart_rx_quad_bench.sv
module uart_rx_quad_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic [1:0] cfg_par = 2'b11;
    logic       cfg_force = 1'b0;
    logic       pop = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rd_data;
    logic       rd_ready, rd_full, st_parity, st_framing, st_break, st_overrun;
    logic       brk_start, brk_end;

    int tests = 0;
    int fails = 0;
    int n_bs = 0;
    int n_be = 0;
    bit done = 0;

    localparam int BIT_CLKS = 32;  // 16 ticks, one tick every 2 clocks

    always #2.5 clk = ~clk;

    always @(negedge clk) tick16 <= rst ? 1'b0 : ~tick16;

    always @(negedge clk) begin
        if (!rst) begin
            if (brk_start) n_bs++;
            if (brk_end)   n_be++;
        end
    end

    uart_rx_quad u_uart_rx_quad (
        .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_force(cfg_force),
        .pop(pop), .err_clr(err_clr), .rd_data(rd_data), .rd_ready(rd_ready),
        .rd_full(rd_full), .st_parity(st_parity), .st_framing(st_framing),
        .st_break(st_break), .st_overrun(st_overrun),
        .brk_start(brk_start), .brk_end(brk_end)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_par(input logic [7:0] d, input logic [1:0] m,
                                     input logic f);
        case (m)
            2'b00:   return ^d;
            2'b01:   return ~(^d);
            default: return f;
        endcase
    endfunction

    function automatic logic [7:0] pattern(input int k);
        case (k)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'hA5;
            3: return 8'h5A;
            4: return 8'h01;
            default: return 8'h80;
        endcase
    endfunction

    task automatic line_bit(input logic v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic flip, input logic stop);
        int n;
        n = int'(cfg_len) + 5;
        line_bit(1'b0);
        for (int i = 0; i < n; i++) line_bit(d[i]);
        if (cfg_par != 2'b11) line_bit(exp_par(d & 8'((1 << n) - 1), cfg_par, cfg_force) ^ flip);
        line_bit(stop);
        line_bit(1'b1);
        line_bit(1'b1);
    endtask

    task automatic do_pop();
        @(negedge clk) pop = 1'b1;
        @(negedge clk) pop = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (400000) @(negedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0] m, d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // reset state, R6
        check("R6", "ready after reset", rd_ready, 0);
        check("R6", "full after reset", rd_full, 0);
        check("R6", "overrun after reset", st_overrun, 0);
        check("R6", "data after reset", rd_data, 0);

        // pop while empty, R7
        do_pop();
        check("R7", "empty pop keeps ready low", rd_ready, 0);
        check("R7", "empty pop no overrun", st_overrun, 0);

        // format sweep, R1 R2
        for (int l = 0; l < 4; l++) begin
            for (int p = 0; p < 4; p++) begin
                for (int k = 0; k < 6; k++) begin
                    cfg_len   = 2'(l);
                    cfg_par   = 2'(p);
                    cfg_force = k[0];
                    m = 8'((1 << (l + 5)) - 1);
                    d = pattern(k);
                    send_frame(d, 1'b0, 1'b1);
                    check("R1", "sweep ready", rd_ready, 1);
                    check("R1", "sweep data", rd_data, d & m);
                    check("R2", "sweep parity clean", st_parity, 0);
                    check("R4", "sweep framing clean", st_framing, 0);
                    do_pop();
                    check("R7", "sweep drained", rd_ready, 0);
                end
                if (p != 3) begin
                    d = 8'h36;
                    send_frame(d, 1'b1, 1'b1);
                    check("R2", "bad parity flagged", st_parity, 1);
                    check("R2", "bad parity data", rd_data, d & m);
                    do_pop();
                    send_frame(d, 1'b0, 1'b1);
                    check("R2", "next char parity clean", st_parity, 0);
                    do_pop();
                end
            end
        end

        // framing error, R4
        cfg_len = 2'b11; cfg_par = 2'b11;
        send_frame(8'h55, 1'b0, 1'b0);
        check("R4", "framing flag", st_framing, 1);
        check("R4", "framing data", rd_data, 8'h55);
        check("R4", "framing not break", st_break, 0);
        do_pop();
        check("R4", "single framing char", rd_ready, 0);

        // false start, R3
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT_CLKS * 12) @(negedge clk);
        check("R3", "false start ignored", rd_ready, 0);

        // break from idle, R5
        rxd = 1'b0;
        repeat (BIT_CLKS * 30) @(negedge clk);
        check("R5", "break start pulse", n_bs, 1);
        check("R5", "no break end yet", n_be, 0);
        check("R5", "break entry stored", rd_ready, 1);
        check("R5", "break flag", st_break, 1);
        check("R5", "break data", rd_data, 0);
        do_pop();
        check("R5", "one break entry", rd_ready, 0);
        rxd = 1'b1;
        repeat (BIT_CLKS * 3) @(negedge clk);
        check("R5", "break end pulse", n_be, 1);

        // mid-character break, R5
        line_bit(1'b0);
        line_bit(1'b1);
        rxd = 1'b0;
        repeat (BIT_CLKS * 30) @(negedge clk);
        check("R5", "interrupted char data", rd_data, 8'h01);
        check("R5", "interrupted char framing", st_framing, 1);
        check("R5", "interrupted char not break", st_break, 0);
        do_pop();
        check("R5", "mid break entry", st_break, 1);
        check("R5", "mid break data", rd_data, 0);
        do_pop();
        check("R5", "mid break single entry", rd_ready, 0);
        check("R5", "mid break start pulses", n_bs, 2);
        rxd = 1'b1;
        repeat (BIT_CLKS * 3) @(negedge clk);
        check("R5", "mid break end pulses", n_be, 2);

        // fill and overrun, R6 R8
        for (int i = 1; i <= 3; i++) send_frame(8'(i), 1'b0, 1'b1);
        check("R6", "three held not full", rd_full, 0);
        send_frame(8'd4, 1'b0, 1'b1);
        check("R6", "four held full", rd_full, 1);
        check("R8", "no overrun yet", st_overrun, 0);
        send_frame(8'd5, 1'b0, 1'b1);
        check("R8", "overrun set", st_overrun, 1);
        check("R8", "still full", rd_full, 1);
        for (int i = 1; i <= 4; i++) begin
            check("R8", "held char intact", rd_data, 32'(i));
            do_pop();
        end
        check("R7", "drained after overrun", rd_ready, 0);
        check("R8", "overrun sticky", st_overrun, 1);
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
        @(negedge clk);
        check("R8", "overrun cleared", st_overrun, 0);

        // pop colliding with arrival, R9
        for (int off = 290; off < 322; off++) begin
            for (int i = 0; i < 3; i++) send_frame(8'h10 + 8'(i), 1'b0, 1'b1);
            fork
                send_frame(8'h13, 1'b0, 1'b1);
                begin
                    repeat (off) @(negedge clk);
                    pop = 1'b1;
                    @(negedge clk) pop = 1'b0;
                end
            join
            check("R9", "no overrun on collision", st_overrun, 0);
            for (int i = 1; i <= 3; i++) begin
                check("R9", "collision order", rd_data, 32'h10 + 32'(i));
                do_pop();
            end
            check("R9", "collision drained", rd_ready, 0);
        end

        done = 1;
        summary();
    end
endmodule